// File: doc/BRIEF.md
# NAND page read sequencer

This block is the device-side read path of a byte-wide NAND-style flash. Write strobes carry command bytes when the command-latch input is high and address bytes when the address-latch input is high. A read command is followed by three address bytes. After the third address byte the block drops its ready output for a fixed number of clock cycles. During that time it copies one 528-byte page from a synchronous array model into an internal data register. Each later read strobe then returns one byte and advances the column.

When the column reaches the end of the page, the page number increments, the column returns to zero, and a new busy reload starts by itself. Where the page ends depends on a spare-area input. When that input is high, the last column is 511. When it is low, the spare bytes up to 527 are included. A reset command or a chip-enable change cancels an active transfer. A status command switches read strobes to return a ready flag.

Top module: `nand_page_reader`

## Requirements
- R1: After reset, `ready` is 1, `dout` is 8'h00 and `mem_rd` is 0.
- R2: Command 8'h00 or 8'h01 is followed by three address bytes. The first address byte gives column bits [7:0], and column bit 8 equals bit 0 of the command. The second byte gives page bits [7:0]. Bits [5:0] of the third byte give page bits [13:8], and its bits [7:6] are ignored.
- R3: `ready` goes low in the cycle after the third address strobe and stays low for exactly BUSY_CYCLES cycles. `mem_rd` is only asserted while `ready` is low.
- R4: While ready and in data mode, each read strobe puts the data-register byte at the current column on `dout` in the next cycle, and advances the column by one.
- R5: With `spare_dis` high, the read of column 511 ends the page. The page increments, the column returns to 0, and `ready` goes low for a reload.
- R6: With `spare_dis` low, the column runs through 527 before the same page advance and reload happen.
- R7: `spare_dis` is sampled every cycle until column 510 has been read. A change after that read does not affect where the current page ends.
- R8: While busy, every command other than 8'hFF and 8'h70 is ignored, and so are all address bytes. The transfer resumes at the original location.
- R9: Command 8'hFF returns the block to idle, sets `ready` in the next cycle and stops array reads. Read strobes are then ignored until a new read command arrives.
- R10: A change of `ce_n` while busy aborts the transfer, so `ready` is high in the next cycle. The block then stays idle.
- R11: After command 8'h70, a read strobe returns 8'h40 when ready and 8'h00 when busy.
- R12: Write and read strobes have no effect while `ce_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip enable |
| cle | input | 1 | Marks write strobe as command byte |
| ale | input | 1 | Marks write strobe as address byte |
| we_stb | input | 1 | One-cycle write strobe |
| re_stb | input | 1 | One-cycle read strobe |
| spare_dis | input | 1 | High: page ends at column 511; low: at 527 |
| din | input | 8 | Command or address byte |
| dout | output | 8 | Byte returned by the last read strobe |
| ready | output | 1 | High when no page transfer is running |
| mem_rd | output | 1 | Array read request |
| mem_page | output | 14 | Array page address |
| mem_col | output | 10 | Array column address |
| mem_rdata | input | 8 | Array data, valid one cycle after `mem_rd` |

## Verification
The assertions assume that strobes last one cycle and that `cle` and `ale` are never high together. They also assume the array answers every `mem_rd` with data in the next cycle, and that BUSY_CYCLES is at least 529 so the whole page fits in the busy window. The bench drives each strobe as a single-cycle pulse with an idle cycle after it, and keeps the two latch inputs exclusive. Its array model registers a value computed from page and column on each request, which gives the one-cycle read latency. It keeps the default busy length.

// File: rtl/nand_page_reader.sv
module nand_page_reader #(
  parameter int PAGE_W      = 14,
  parameter int MAIN_BYTES  = 512,
  parameter int SPARE_BYTES = 16,
  parameter int BUSY_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              cle,
  input  logic              ale,
  input  logic              we_stb,
  input  logic              re_stb,
  input  logic              spare_dis,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ready,
  output logic              mem_rd,
  output logic [PAGE_W-1:0] mem_page,
  output logic [$clog2(MAIN_BYTES+SPARE_BYTES)-1:0] mem_col,
  input  logic [7:0]        mem_rdata
);
  localparam int PAGE_BYTES = MAIN_BYTES + SPARE_BYTES;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int CNT_W      = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {IDLE, ADDR, DATA} mode_t;

  mode_t             state;
  logic              busy, stat, half, spare_lat, ce_q;
  logic [1:0]        acnt;
  logic [CNT_W-1:0]  cnt;
  logic [COL_W-1:0]  col, last;
  logic [PAGE_W-1:0] page;
  logic [7:0]        dreg [PAGE_BYTES];

  wire cmd_wr  = we_stb & ~ce_n & cle & ~ale;
  wire adr_wr  = we_stb & ~ce_n & ale & ~cle;
  wire rd      = re_stb & ~ce_n;
  wire ce_edge = ce_q != ce_n;
  wire do_rst  = cmd_wr && din == 8'hFF;

  assign last     = spare_lat ? COL_W'(MAIN_BYTES - 1) : COL_W'(PAGE_BYTES - 1);
  assign ready    = ~busy;
  assign mem_rd   = busy && cnt < CNT_W'(PAGE_BYTES);
  assign mem_col  = COL_W'(cnt);
  assign mem_page = page;

  always_ff @(posedge clk)
    if (busy && cnt != '0 && cnt <= CNT_W'(PAGE_BYTES))
      dreg[COL_W'(cnt - 1'b1)] <= mem_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= IDLE; busy <= 1'b0; stat <= 1'b0; half <= 1'b0;
      spare_lat <= 1'b0; ce_q <= 1'b1; acnt <= '0; cnt <= '0;
      col <= '0; page <= '0; dout <= 8'h00;
    end else begin
      ce_q <= ce_n;
      if (!(state == DATA && col >= COL_W'(MAIN_BYTES - 1)))
        spare_lat <= spare_dis;
      if (busy) begin
        cnt <= cnt + 1'b1;
        if (cnt == CNT_W'(BUSY_CYCLES - 1)) begin
          busy  <= 1'b0;
          state <= DATA;
        end
      end
      if (do_rst || (busy && ce_edge)) begin
        busy <= 1'b0; state <= IDLE; stat <= 1'b0; cnt <= '0;
      end else if (cmd_wr && din == 8'h70) begin
        stat <= 1'b1;
      end else if (cmd_wr && !busy && (din == 8'h00 || din == 8'h01)) begin
        state <= ADDR; acnt <= '0; half <= din[0]; stat <= 1'b0;
      end else if (adr_wr && !busy && state == ADDR) begin
        acnt <= acnt + 1'b1;
        case (acnt)
          2'd0:    col <= COL_W'({half, din});
          2'd1:    page[7:0] <= din;
          default: begin
            page[PAGE_W-1:8] <= din[PAGE_W-9:0];
            busy <= 1'b1; cnt <= '0; state <= DATA;
          end
        endcase
      end else if (rd && stat) begin
        dout <= {1'b0, ~busy, 6'b0};
      end else if (rd && !busy && state == DATA) begin
        dout <= dreg[col];
        if (col >= last) begin
          col <= '0; page <= page + 1'b1; busy <= 1'b1; cnt <= '0;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  // R3
  mem_rd_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !ready);

  // R3
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CNT_W'(BUSY_CYCLES));

  // R4
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col < COL_W'(PAGE_BYTES));

  // R9
  reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_rst |=> ready && !mem_rd);

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && ready && !stat && state == DATA && col == last) |=> !ready && col == '0);

  // R8
  busy_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && adr_wr) |=> $stable(page));
endmodule

// File: tb/nand_page_reader_tb.sv
module nand_page_reader_tb;
  localparam int BUSY = 600;

  logic clk = 1'b0, rst_n = 1'b0, ce_n = 1'b0, cle = 1'b0, ale = 1'b0;
  logic we_stb = 1'b0, re_stb = 1'b0, spare_dis = 1'b0;
  logic [7:0] din = 8'h00, dout, mem_rdata = 8'h00;
  logic ready, mem_rd;
  logic [13:0] mem_page;
  logic [9:0]  mem_col;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  nand_page_reader #(.BUSY_CYCLES(BUSY)) u_dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale),
    .we_stb(we_stb), .re_stb(re_stb), .spare_dis(spare_dis), .din(din),
    .dout(dout), .ready(ready), .mem_rd(mem_rd), .mem_page(mem_page),
    .mem_col(mem_col), .mem_rdata(mem_rdata));

  function automatic logic [7:0] pat(int pg, int c);
    return 8'((c & 255) ^ ((c >> 8) * 165) ^ (pg * 29) ^ ((pg >> 8) * 7));
  endfunction

  always @(posedge clk) if (mem_rd) mem_rdata <= pat(int'(mem_page), int'(mem_col));

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [7:0] d);
    cle = c; ale = a; din = d; we_stb = 1'b1;
    @(negedge clk);
    we_stb = 1'b0; cle = 1'b0; ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic rdb(output logic [7:0] b);
    re_stb = 1'b1;
    @(negedge clk);
    re_stb = 1'b0;
    b = dout;
    @(negedge clk);
  endtask

  task automatic start(input logic [7:0] c, input logic [7:0] a0, a1, a2);
    wr(1, 0, c); wr(0, 1, a0); wr(0, 1, a1);
    cle = 1'b0; ale = 1'b1; din = a2; we_stb = 1'b1;
    @(negedge clk);
    we_stb = 1'b0; ale = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  localparam logic [63:0] VEC [5] = '{
    {8'h00, 8'h10, 8'h05, 8'h00, 16'd16,  16'h0005},
    {8'h01, 8'h10, 8'h05, 8'h00, 16'd272, 16'h0005},
    {8'h00, 8'h00, 8'h34, 8'h12, 16'd0,   16'h1234},
    {8'h01, 8'hFF, 8'hFF, 8'h3F, 16'd511, 16'h3FFF},
    {8'h00, 8'h00, 8'h00, 8'hFF, 16'd0,   16'h3F00}
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] b;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && dout == 8'h00 && !mem_rd, "R1 reset", {ready, dout, mem_rd}, 10'h200);

    for (int i = 0; i < 5; i++) begin
      logic [63:0] v = VEC[i];
      start(v[63:56], v[55:48], v[47:40], v[39:32]);
      check(!ready, "R3 busy start", ready, 0);
      wait_ready(n);
      check(n == BUSY, "R3 busy length", n, BUSY);
      for (int k = 0; k < 3; k++) begin
        rdb(b);
        check(b == pat(int'(v[15:0]), int'(v[31:16]) + k), "R2 R4 vector read",
              b, pat(int'(v[15:0]), int'(v[31:16]) + k));
      end
    end

    // R12: strobes with chip disabled
    ce_n = 1'b1;
    start(8'h00, 8'h00, 8'h01, 8'h00);
    @(negedge clk);
    check(ready, "R12 ignored when disabled", ready, 1);
    ce_n = 1'b0;
    @(negedge clk);

    // R5 R7: spare disabled just before column 510
    spare_dis = 1'b0;
    start(8'h01, 8'd250, 8'd7, 8'd0);
    wait_ready(n);
    for (int k = 506; k < 510; k++) begin
      rdb(b); check(b == pat(7, k), "R4 sequential", b, pat(7, k));
    end
    spare_dis = 1'b1;
    rdb(b); check(b == pat(7, 510), "R7 col 510", b, pat(7, 510));
    rdb(b); check(b == pat(7, 511), "R5 col 511", b, pat(7, 511));
    check(!ready, "R5 reload after 511", ready, 0);
    wait_ready(n);
    rdb(b); check(b == pat(8, 0), "R5 next page", b, pat(8, 0));

    // R7: change after column 510 read has no effect
    start(8'h01, 8'd250, 8'd20, 8'd0);
    wait_ready(n);
    for (int k = 506; k <= 510; k++) rdb(b);
    spare_dis = 1'b0;
    rdb(b); check(b == pat(20, 511), "R7 col 511", b, pat(20, 511));
    check(!ready, "R7 late change ignored", ready, 0);
    wait_ready(n);

    // R6: spare area read through 527
    start(8'h01, 8'd250, 8'd40, 8'd0);
    wait_ready(n);
    for (int k = 506; k <= 527; k++) begin
      rdb(b); check(b == pat(40, k), "R6 spare read", b, pat(40, k));
      if (k == 511) check(ready, "R6 no wrap at 511", ready, 1);
    end
    check(!ready, "R6 reload after 527", ready, 0);
    wait_ready(n);
    rdb(b); check(b == pat(41, 0), "R6 next page", b, pat(41, 0));

    // R8 R11: foreign commands ignored, status accepted while busy
    start(8'h00, 8'h20, 8'd3, 8'd0);
    start(8'h00, 8'h40, 8'd9, 8'd0);
    wr(1, 0, 8'h80);
    wr(1, 0, 8'h70);
    rdb(b); check(b == 8'h00, "R11 status busy", b, 8'h00);
    wait_ready(n);
    rdb(b); check(b == 8'h40, "R11 status ready", b, 8'h40);
    start(8'h00, 8'h20, 8'd3, 8'd0);
    start(8'h00, 8'h40, 8'd9, 8'd0);
    wait_ready(n);
    rdb(b); check(b == pat(3, 32), "R8 original location", b, pat(3, 32));

    // R9: reset command during busy
    start(8'h00, 8'h00, 8'd50, 8'd0);
    repeat (10) @(negedge clk);
    wr(1, 0, 8'hFF);
    check(ready && !mem_rd, "R9 reset cancels", {ready, mem_rd}, 2'b10);
    rdb(b); check(b == pat(3, 32), "R9 reads ignored", b, pat(3, 32));

    // R10: chip-enable change aborts
    start(8'h00, 8'h05, 8'd60, 8'd0);
    repeat (10) @(negedge clk);
    ce_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b0;
    check(ready, "R10 abort", ready, 1);
    @(negedge clk);
    rdb(b); check(b == pat(3, 32), "R10 idle after abort", b, pat(3, 32));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule